// File: doc/BRIEF.md
# Programmable Interrupt Controller

This block gathers twelve interrupt request lines from neighbouring peripherals (the buffer manager on line 0, the pulse-per-second tick on line 7, serial receive and transmit on lines 8 and 9, clock status on line 11, and others) into one interrupt output for the processor. Software chooses, separately for each line, whether the line is edge-triggered or level-sensitive and which polarity counts as active. It can also disable each line's contribution to the output.

Each line owns one pending bit. An active edge or level sets the bit. The bit stays set until software writes a one to it. The register port is a plain synchronous write strobe with a two-bit address and a data word, plus a read word that shows the addressed register combinationally. No data streams through the block, so every pin is a plain control or status signal and none uses a handshake.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, all pending bits are 0, all disable bits are 1, all polarity bits are 1 and all trigger-mode bits are 0, so `irq_o` is low.
- R2: Address 0 selects pending, 1 selects disable, 2 selects trigger mode and 3 selects polarity. Bit n of each register belongs to line n. A write with `wr_en` high stores the low 12 bits of `wr_data` into the disable, trigger-mode and polarity registers at the next clock edge. `rd_data` shows the addressed register in bits 11:0 and zeros above.
- R3: A line with trigger mode 1 and polarity 1 sets its pending bit at the first clock edge that sees it high after it was low at the previous edge. It sets the bit once per transition, so holding the line high does not set the bit again after a clear.
- R4: A line with trigger mode 1 and polarity 0 sets its pending bit on a high-to-low transition in the same way, and a rising transition has no effect.
- R5: A line with trigger mode 0 sets its pending bit at every clock edge where the line equals its polarity bit (1 means active high, 0 means active low). The bit stays set after the line goes inactive, until it is cleared.
- R6: Writing address 0 clears every pending bit whose data bit is 1 at that clock edge. Bits written with 0 are left as they are, and writing 1 never sets a bit.
- R7: When a level-sensitive line is cleared while it is still active, its pending bit reads 0 for one cycle and is set again at the following edge.
- R8: When a clear and a qualifying edge reach the same line at the same clock edge, the edge wins and the bit stays set.
- R9: `irq_o` is high exactly when some pending bit has its disable bit at 0. A disabled line still collects pending state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 12 | Interrupt request lines, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for read and write |
| wr_data | input | 32 | Write data; bits 11:0 used |
| rd_data | output | 32 | Addressed register, upper bits zero |
| irq_o | output | 1 | Combined processor interrupt |

## Verification
A wrong edge history or a stuck pending bit shows at the ports one clock edge after the stimulus. It appears either as a pending bit that reads back wrong or as `irq_o` rising or falling one cycle out of step. Every stimulus step is therefore checked at the edge directly after it, through the pending read port and the interrupt pin together. Clear-versus-edge and clear-versus-level races are timed to land on the same edge. Lines that are disabled are checked through the read port, because `irq_o` cannot show their state.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_DIS  = 2'd1,
    SEL_TRIG = 2'd2,
    SEL_POL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  reg_sel_e             sel,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] dis_q,
  output logic [NUM_LINES-1:0] trig_q,
  output logic [NUM_LINES-1:0] pol_q
);
  // R1 reset values: every line disabled, level mode, active high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q  <= '1;
      trig_q <= '0;
      pol_q  <= '1;
    end else if (wr_en) begin
      unique case (sel)
        SEL_DIS:  dis_q  <= wdata;
        SEL_TRIG: trig_q <= wdata;
        SEL_POL:  pol_q  <= wdata;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/irq_line.sv
module irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic trig_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q;
  logic edge_hit, level_hit;

  always_comb begin
    edge_hit  = trig_i & (pol_i ? (req_i & ~prev_q) : (~req_i & prev_q));
    level_hit = ~trig_i & (req_i == pol_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev_q <= req_i;
      // An edge beats a clear (R8); a level is cleared for one cycle (R7)
      pend_o <= (pend_o & ~clr_i) | edge_hit | (level_hit & ~clr_i);
    end
  end

  // R3 / R4 / R8: a qualifying transition always leaves the bit set
  p_edge_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && (pol_i ? $rose(req_i) : $fell(req_i))) |=> pend_o);

  // R5: an active level with no clear sets the bit
  p_level_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && (req_i == pol_i) && !clr_i) |=> pend_o);

  // R6: the bit only drops through a clear write
  p_drop_needs_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_o) |-> $past(clr_i));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 12,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic                 wr_en,
  input  logic [1:0]           addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 irq_o
);
  localparam int PAD_W = DATA_W - NUM_LINES;

  reg_sel_e             sel;
  logic [NUM_LINES-1:0] dis_q, trig_q, pol_q, pend_q, clr;
  logic [NUM_LINES-1:0] rd_sel;

  assign sel = reg_sel_e'(addr);
  assign clr = (wr_en && sel == SEL_PEND) ? wr_data[NUM_LINES-1:0] : '0;

  irq_cfg_regs #(.NUM_LINES(NUM_LINES)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .sel   (sel),
    .wdata (wr_data[NUM_LINES-1:0]),
    .dis_q (dis_q),
    .trig_q(trig_q),
    .pol_q (pol_q)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    irq_line u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (req_i[i]),
      .trig_i(trig_q[i]),
      .pol_i (pol_q[i]),
      .clr_i (clr[i]),
      .pend_o(pend_q[i])
    );
  end

  always_comb begin
    unique case (sel)
      SEL_PEND: rd_sel = pend_q;
      SEL_DIS:  rd_sel = dis_q;
      SEL_TRIG: rd_sel = trig_q;
      default:  rd_sel = pol_q;
    endcase
  end

  assign rd_data = {{PAD_W{1'b0}}, rd_sel};
  assign irq_o   = |(pend_q & ~dis_q);

  // R9: with every line disabled the output is quiet
  p_all_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&dis_q) |-> !irq_o);

  // R9: the output only falls after a register write
  p_irq_falls_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> (irq_o || $past(wr_en)));
endmodule

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 12;
  localparam int NV = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_i = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl u_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
  );

  // {req, wr_en, addr, wdata, expected pending, expected irq}
  // lines: 0 rising edge, 1 falling edge, 2 level high, 3 level low
  localparam logic [39:0] VEC [NV] = '{
    {12'h000, 1'b1, 2'd2, 12'h003, 12'h000, 1'b0}, // 0  R2 trig
    {12'h000, 1'b1, 2'd3, 12'hFF5, 12'h000, 1'b0}, // 1  R2 polarity
    {12'h008, 1'b0, 2'd0, 12'h000, 12'h000, 1'b0}, // 2
    {12'h008, 1'b1, 2'd1, 12'h000, 12'h000, 1'b0}, // 3  enable all
    {12'h009, 1'b0, 2'd0, 12'h000, 12'h001, 1'b1}, // 4  R3 rise
    {12'h009, 1'b1, 2'd0, 12'h001, 12'h000, 1'b0}, // 5  R6 clear
    {12'h009, 1'b0, 2'd0, 12'h000, 12'h000, 1'b0}, // 6  R3 held, no reset
    {12'h00B, 1'b0, 2'd0, 12'h000, 12'h000, 1'b0}, // 7  R4 rise ignored
    {12'h009, 1'b0, 2'd0, 12'h000, 12'h002, 1'b1}, // 8  R4 fall
    {12'h00D, 1'b0, 2'd0, 12'h000, 12'h006, 1'b1}, // 9  R5 level high
    {12'h009, 1'b0, 2'd0, 12'h000, 12'h006, 1'b1}, // 10 R5 sticky
    {12'h009, 1'b1, 2'd0, 12'h004, 12'h002, 1'b1}, // 11 R6
    {12'h001, 1'b0, 2'd0, 12'h000, 12'h00A, 1'b1}, // 12 R5 level low
    {12'h001, 1'b1, 2'd0, 12'h008, 12'h002, 1'b1}, // 13 R7 cleared
    {12'h001, 1'b0, 2'd0, 12'h000, 12'h00A, 1'b1}, // 14 R7 re-set
    {12'h009, 1'b1, 2'd0, 12'h00A, 12'h000, 1'b0}, // 15 R6
    {12'h009, 1'b1, 2'd1, 12'hFFE, 12'h000, 1'b0}, // 16 only line0 on
    {12'h00D, 1'b0, 2'd0, 12'h000, 12'h004, 1'b0}, // 17 R9 disabled pends
    {12'h008, 1'b0, 2'd0, 12'h000, 12'h004, 1'b0}, // 18
    {12'h009, 1'b1, 2'd0, 12'h001, 12'h005, 1'b1}, // 19 R8 edge wins
    {12'h009, 1'b1, 2'd0, 12'h005, 12'h000, 1'b0}, // 20 R6
    {12'h00D, 1'b0, 2'd0, 12'h000, 12'h004, 1'b0}, // 21
    {12'h009, 1'b1, 2'd0, 12'h000, 12'h004, 1'b0}, // 22 R6 zeros no effect
    {12'h009, 1'b1, 2'd0, 12'hFFF, 12'h000, 1'b0}  // 23 R6 ones never set
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] a, input string req, input logic [31:0] exp);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    #1 check(req, rd_data, exp);
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = {20'h0, d};
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state, R2 read layout
    read_reg(2'd0, "R1 pending", 32'h0);
    read_reg(2'd1, "R1 disable", 32'h0000_0FFF);
    read_reg(2'd2, "R1 trigger", 32'h0);
    read_reg(2'd3, "R1 polarity", 32'h0000_0FFF);
    checks++; if (irq_o !== 1'b0) begin errors++; $display("FAIL R1 irq: actual %b expected 0", irq_o); end

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      req_i = VEC[v][39:28]; wr_en = VEC[v][27]; addr = VEC[v][26:25];
      wr_data = {20'h0, VEC[v][24:13]};
      @(posedge clk);
      #1 wr_en = 1'b0; addr = 2'd0;
      #1;
      check($sformatf("R3-R9 vector %0d pending", v), rd_data, {20'h0, VEC[v][12:1]});
      check($sformatf("R9 vector %0d irq", v), {31'h0, irq_o}, {31'h0, VEC[v][0]});
    end

    // R2 read-back of stored configuration, upper data bits dropped
    read_reg(2'd1, "R2 disable readback", 32'h0000_0FFE);
    read_reg(2'd2, "R2 trigger readback", 32'h0000_0003);
    read_reg(2'd3, "R2 polarity readback", 32'h0000_0FF5);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd2; wr_data = 32'hFFFF_F00F;
    @(posedge clk); #1 wr_en = 1'b0;
    read_reg(2'd2, "R2 upper bits zero", 32'h0000_000F);
    write_reg(2'd2, 12'h003);

    // R1 reset in mid-run clears pending and restores configuration
    @(negedge clk) req_i = 12'h00D;
    @(posedge clk); #1;
    read_reg(2'd0, "R5 pending before reset", 32'h0000_0004);
    rst_n = 1'b0; req_i = 12'h000;
    #1 check("R1 pending after reset", rd_data, 32'h0);
    checks++; if (irq_o !== 1'b0) begin errors++; $display("FAIL R1 irq after reset: actual %b expected 0", irq_o); end
    @(negedge clk) rst_n = 1'b1;
    read_reg(2'd1, "R1 disable after reset", 32'h0000_0FFF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule